// File: doc/BRIEF.md
# Branch target generator

This block forms the next-fetch address and the return address for the two immediate branch kinds of a 64-bit machine with 32-bit instructions. One kind carries a long 24-bit signed word displacement. The other is a conditional branch with a short 14-bit signed word displacement. A form-select input says which kind the current instruction word is. The displacement is scaled to bytes by appending two zero bits. It is then sign-extended to the address width. An absolute-mode bit in the instruction chooses between using that value on its own and adding it to the branch's own address.

A link bit in the instruction asks for the return address to be saved. The block raises a write enable for the link register in that case. It always presents the branch address plus four as the link value. Deciding whether a conditional branch is taken is the job of neighbouring logic, and so are redirecting fetch and flushing the pipeline. With the output register enabled (the default), every result appears one clock after its inputs. Reset clears the registered outputs to zero.

Instruction bits are written here as little-endian vector indices. Bit 31 of the vector is the first bit of the instruction word.

Top module: `bta_gen`

## Requirements
- R1: With the form select high, the displacement is instruction bits [25:2], taken as a 24-bit two's complement word count. It is multiplied by four and sign-extended to 64 bits.
- R2: With the form select low, the displacement is instruction bits [15:2], taken as a 14-bit two's complement word count. It is multiplied by four and sign-extended to 64 bits.
- R3: When instruction bit 1 (absolute mode) is 0, the target is the branch address plus the extended displacement.
- R4: When instruction bit 1 is 1, the target is the extended displacement alone, and the branch address does not contribute.
- R5: The link write enable equals instruction bit 0: it is 1 when the return address must be saved and 0 otherwise.
- R6: The link value is the branch address plus 4, modulo 2^64, whatever the value of bit 0.
- R7: Instruction bits outside the selected displacement field, the absolute bit and the link bit have no effect on the target. In particular, bits [25:16] are ignored in the short form.
- R8: With OUT_REG = 1, the outputs change one clock after the inputs that produce them. While reset is asserted, the target, link enable and link value are all zero.
- R9: Both additions wrap modulo 2^64 and raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Branch instruction word, bit 31 first in the word |
| pc_i | input | 64 | Address of the branch instruction |
| long_form_i | input | 1 | 1: long displacement form, 0: short conditional form |
| target_o | output | 64 | Computed branch target address |
| link_we_o | output | 1 | Link register write enable |
| link_val_o | output | 64 | Address of the following instruction |

## Verification
The bench aims at the ends of both displacement ranges: the largest positive value and the most negative value of each field. A design that pulled the sign from the wrong bit, or that dropped the two appended zeros, would turn these targets into huge or misaligned addresses. It also drives absolute mode with negative displacements, where a design that still added the branch address, or that zero-extended, would be exposed. Branch addresses at the top of the 64-bit space check that the target and the link value wrap to small values, and a short-form word is replayed with the long form selected to prove that the select really changes which bits are read.

// File: rtl/bta_pkg.sv
package bta_pkg;
    // Fixed instruction encoding positions (little-endian vector indices)
    localparam int INSTR_W     = 32;
    localparam int LINK_BIT    = 0;
    localparam int ABS_BIT     = 1;
    localparam int ALIGN_BITS  = 2;
    localparam int LONG_DISP_W = 24;
    localparam int COND_DISP_W = 14;
    localparam int INSTR_BYTES = 4;

    typedef enum logic {
        FORM_COND = 1'b0,
        FORM_LONG = 1'b1
    } form_e;
endpackage

// File: rtl/bta_disp_ext.sv
module bta_disp_ext
    import bta_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [LONG_DISP_W+ALIGN_BITS-1:ALIGN_BITS] field_i,
    input  form_e                                       form_i,
    output logic [ADDR_W-1:0]                           disp_o
);
    localparam int LONG_PAD = ADDR_W - LONG_DISP_W - ALIGN_BITS;
    localparam int COND_PAD = ADDR_W - COND_DISP_W - ALIGN_BITS;
    localparam int COND_TOP = COND_DISP_W + ALIGN_BITS - 1;
    localparam int LONG_TOP = LONG_DISP_W + ALIGN_BITS - 1;

    logic [ADDR_W-1:0] long_ext;
    logic [ADDR_W-1:0] cond_ext;

    always_comb begin
        long_ext = {{LONG_PAD{field_i[LONG_TOP]}},
                    field_i[LONG_TOP:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        cond_ext = {{COND_PAD{field_i[COND_TOP]}},
                    field_i[COND_TOP:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        unique case (form_i)
            FORM_LONG: disp_o = long_ext;
            FORM_COND: disp_o = cond_ext;
            default:   disp_o = cond_ext;
        endcase
    end
endmodule

// File: rtl/bta_tgt_sel.sv
module bta_tgt_sel #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] disp_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              abs_i,
    output logic [ADDR_W-1:0] target_o
);
    logic [ADDR_W-1:0] base;

    always_comb begin
        base     = abs_i ? '0 : pc_i;
        target_o = base + disp_i;  // wraps modulo 2^ADDR_W
    end
endmodule

// File: rtl/bta_link_gen.sv
module bta_link_gen
    import bta_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              link_bit_i,
    output logic              link_we_o,
    output logic [ADDR_W-1:0] link_val_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    always_comb begin
        link_we_o  = link_bit_i;
        link_val_o = pc_i + STEP;
    end
endmodule

// File: rtl/bta_gen.sv
module bta_gen
    import bta_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       instr_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              long_form_i,
    output logic [ADDR_W-1:0] target_o,
    output logic              link_we_o,
    output logic [ADDR_W-1:0] link_val_o
);
    localparam int FIELD_HI = LONG_DISP_W + ALIGN_BITS - 1;

    form_e             form;
    logic [ADDR_W-1:0] disp;
    logic [ADDR_W-1:0] tgt_c;
    logic              we_c;
    logic [ADDR_W-1:0] lnk_c;
    logic              unused_opcode;

    assign form          = form_e'(long_form_i);
    assign unused_opcode = ^instr_i[INSTR_W-1:FIELD_HI+1];

    bta_disp_ext #(.ADDR_W(ADDR_W)) u_disp (
        .field_i (instr_i[FIELD_HI:ALIGN_BITS]),
        .form_i  (form),
        .disp_o  (disp)
    );

    bta_tgt_sel #(.ADDR_W(ADDR_W)) u_tgt (
        .disp_i   (disp),
        .pc_i     (pc_i),
        .abs_i    (instr_i[ABS_BIT]),
        .target_o (tgt_c)
    );

    bta_link_gen #(.ADDR_W(ADDR_W)) u_link (
        .pc_i       (pc_i),
        .link_bit_i (instr_i[LINK_BIT]),
        .link_we_o  (we_c),
        .link_val_o (lnk_c)
    );

    generate
        if (OUT_REG) begin : g_reg
            logic [ADDR_W-1:0] tgt_q;
            logic              we_q;
            logic [ADDR_W-1:0] lnk_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tgt_q <= '0;
                    we_q  <= 1'b0;
                    lnk_q <= '0;
                end else begin
                    tgt_q <= tgt_c;
                    we_q  <= we_c;
                    lnk_q <= lnk_c;
                end
            end

            always_comb begin
                target_o   = tgt_q;
                link_we_o  = we_q;
                link_val_o = lnk_q;
            end
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;

            always_comb begin
                target_o   = tgt_c;
                link_we_o  = we_c;
                link_val_o = lnk_c;
            end
        end
    endgenerate
endmodule

// File: rtl/bta_gen_chk.sv
module bta_gen_chk #(
    parameter int ADDR_W  = 64,
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       instr_i,
    input logic [ADDR_W-1:0] pc_i,
    input logic              long_form_i,
    input logic [ADDR_W-1:0] target_o,
    input logic              link_we_o,
    input logic [ADDR_W-1:0] link_val_o
);
    logic              ok;
    logic [31:0]       ins_r;
    logic [ADDR_W-1:0] pc_r;
    logic              lng_r;

    generate
        if (OUT_REG) begin : g_reg
            logic              primed_q;
            logic [31:0]       ins_q;
            logic [ADDR_W-1:0] pc_q;
            logic              lng_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    primed_q <= 1'b0;
                    ins_q    <= '0;
                    pc_q     <= '0;
                    lng_q    <= 1'b0;
                end else begin
                    primed_q <= 1'b1;
                    ins_q    <= instr_i;
                    pc_q     <= pc_i;
                    lng_q    <= long_form_i;
                end
            end
            assign ok    = primed_q;
            assign ins_r = ins_q;
            assign pc_r  = pc_q;
            assign lng_r = lng_q;

            // R8
            reset_zero_chk: assert property (@(posedge clk)
                !rst_n |-> (target_o == '0 && !link_we_o && link_val_o == '0));
        end else begin : g_comb
            assign ok    = 1'b1;
            assign ins_r = instr_i;
            assign pc_r  = pc_i;
            assign lng_r = long_form_i;
        end
    endgenerate

    // R5
    link_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> (link_we_o == ins_r[0]));

    // R6
    link_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> (link_val_o == pc_r + ADDR_W'(4)));

    // R4
    abs_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && ins_r[1]) |-> (target_o[1:0] == 2'b00));

    // R3
    rel_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && !ins_r[1]) |-> (target_o[1:0] == pc_r[1:0]));

    // R2
    cond_abs_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && ins_r[1] && !lng_r) |->
        (target_o[ADDR_W-1:15] == (ins_r[15] ? '1 : '0)));

    // R1
    long_abs_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && ins_r[1] && lng_r) |->
        (target_o[ADDR_W-1:25] == (ins_r[25] ? '1 : '0)));
endmodule

bind bta_gen bta_gen_chk #(.ADDR_W(ADDR_W), .OUT_REG(OUT_REG)) u_bta_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_i     (instr_i),
    .pc_i        (pc_i),
    .long_form_i (long_form_i),
    .target_o    (target_o),
    .link_we_o   (link_we_o),
    .link_val_o  (link_val_o)
);

// File: tb/test_bta_gen.sv
module test_bta_gen;
    typedef struct packed {
        logic        lng;
        logic [31:0] ins;
        logic [63:0] pc;
        logic [63:0] tgt;
        logic        we;
        logic [63:0] lnk;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        // R1 R3 simple positive
        '{1'b1, 32'h48000100, 64'h0000_0000_0000_1000, 64'h0000_0000_0000_1100, 1'b0, 64'h0000_0000_0000_1004},
        // R1 largest positive long, link set
        '{1'b1, 32'h49FFFFFD, 64'h0000_0000_1000_0000, 64'h0000_0000_11FF_FFFC, 1'b1, 64'h0000_0000_1000_0004},
        // R1 most negative long
        '{1'b1, 32'h4A000000, 64'h0000_0000_1000_0000, 64'h0000_0000_0E00_0000, 1'b0, 64'h0000_0000_1000_0004},
        // R4 absolute negative long
        '{1'b1, 32'h4BFFFFFE, 64'h0000_0000_0000_1234, 64'hFFFF_FFFF_FFFF_FFFC, 1'b0, 64'h0000_0000_0000_1238},
        // R4 absolute positive with link
        '{1'b1, 32'h48000043, 64'h0000_0000_0000_5000, 64'h0000_0000_0000_0040, 1'b1, 64'h0000_0000_0000_5004},
        // R9 target wraps past top
        '{1'b1, 32'h48000040, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0030, 1'b0, 64'hFFFF_FFFF_FFFF_FFF4},
        // R9 target and link wrap to zero
        '{1'b1, 32'h48000005, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0000_0000_0000_0000, 1'b1, 64'h0000_0000_0000_0000},
        // R2 R7 short form, bits 25:16 set but ignored
        '{1'b0, 32'h43FF0010, 64'h0000_0000_0000_2000, 64'h0000_0000_0000_2010, 1'b0, 64'h0000_0000_0000_2004},
        // R2 largest positive short
        '{1'b0, 32'h43FF7FFC, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_FFFC, 1'b0, 64'h0000_0000_0000_8004},
        // R2 most negative short, link set
        '{1'b0, 32'h40008001, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_0000, 1'b1, 64'h0000_0000_0000_8004},
        // R4 absolute negative short
        '{1'b0, 32'h4000FFFE, 64'h9999_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFC, 1'b0, 64'h9999_0000_0000_0004},
        // R9 relative wrap below zero
        '{1'b0, 32'h4000FFF8, 64'h0000_0000_0000_0004, 64'hFFFF_FFFF_FFFF_FFFC, 1'b0, 64'h0000_0000_0000_0008},
        // R7 same word as row 8 read as long form
        '{1'b1, 32'h43FF0010, 64'h0000_0000_0000_2000, 64'hFFFF_FFFF_FFFF_2010, 1'b0, 64'h0000_0000_0000_2004}
    };

    logic        clk;
    logic        rst_n;
    logic [31:0] instr;
    logic [63:0] pc;
    logic        long_form;
    logic [63:0] target;
    logic        link_we;
    logic [63:0] link_val;

    int n_checks;
    int n_fail;
    bit done;

    bta_gen i_bta_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_i     (instr),
        .pc_i        (pc),
        .long_form_i (long_form),
        .target_o    (target),
        .link_we_o   (link_we),
        .link_val_o  (link_val)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        n_checks  = 0;
        n_fail    = 0;
        done      = 1'b0;
        rst_n     = 1'b0;
        instr     = 32'h48000101;
        pc        = 64'h1000;
        long_form = 1'b1;
        repeat (3) @(negedge clk);
        // R8 reset state
        check64("R8 reset target", target, 64'h0);
        check1 ("R8 reset link_we", link_we, 1'b0);
        check64("R8 reset link_val", link_val, 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            @(negedge clk);
            long_form = VECS[i].lng;
            instr     = VECS[i].ins;
            pc        = VECS[i].pc;
            @(negedge clk);
            tag = {VECS[i].lng ? "R1" : "R2", VECS[i].ins[1] ? " R4" : " R3", " R7 R9"};
            check64($sformatf("%s target row %0d", tag, i), target, VECS[i].tgt);
            check1 ($sformatf("R5 link_we row %0d", i), link_we, VECS[i].we);
            check64($sformatf("R6 link_val row %0d", i), link_val, VECS[i].lnk);
        end

        // R8 one-cycle latency: new input not visible before the clock edge
        @(negedge clk);
        long_form = 1'b1;
        instr     = 32'h48000101;
        pc        = 64'h3000;
        @(negedge clk);
        check64("R8 settled target", target, 64'h3100);
        instr = 32'h48000200;
        pc    = 64'h4000;
        #1;
        check64("R8 target held before edge", target, 64'h3100);
        check1 ("R8 link_we held before edge", link_we, 1'b1);
        @(negedge clk);
        check64("R8 target after edge", target, 64'h4200);
        check1 ("R5 link_we cleared", link_we, 1'b0);

        // R8 reset in mid-run clears outputs at once
        rst_n = 1'b0;
        #1;
        check64("R8 mid-run reset target", target, 64'h0);
        check64("R8 mid-run reset link_val", link_val, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check64("R6 link_val after reset", link_val, 64'h4004);

        finish_run();
    end
endmodule